// File: doc/BRIEF.md
# Paged Program Counter With Return Stack

This block sequences instruction fetch for a small core with 12-bit instructions. It holds the program counter and builds each new fetch address from the decoded control type of the instruction now executing. Jump and call instructions carry only part of a target address. The block supplies the upper address bits from page bits kept in a status register outside the block. A jump carries nine address bits. A call carries eight, so a call can only land in the lower half of a 512-word page.

Computed jumps work by writing a byte to the low part of the program counter. The block also keeps a small return-address stack that software cannot reach. A return-with-literal instruction pops that stack and hands its immediate byte to the accumulator in the same step. A chain of such returns, entered through a computed jump, forms a lookup table.

The fetch address always runs one instruction ahead of execution. Any change of flow therefore discards the instruction already fetched, and the block flags that slot as squashed.

Top module: `paged_pc_seq`

## Requirements
- R1: While reset is asserted, `fetch_addr_o` is all ones (the top of program memory), and `squash_o` and `lit_load_o` are 0.
- R2: Control code 0 (sequential) advances `fetch_addr_o` by one on the next cycle, wrapping from all ones to zero.
- R3: Control code 1 (jump) sets `fetch_addr_o` to {`page_i`, `imm_i[8:0]`}.
- R4: Control code 2 (call) pushes the current `fetch_addr_o` onto the return stack and sets `fetch_addr_o` to {`page_i`, 0, `imm_i[7:0]`}, so address bit 8 is always 0 after a call.
- R5: Control code 3 (return with literal) pops the return stack into `fetch_addr_o`. On the next cycle `lit_o` equals `imm_i[7:0]` and `lit_load_o` pulses high for one cycle.
- R6: Control code 4 (computed jump) sets `fetch_addr_o` to {`page_i`, 0, `wdata_i`}.
- R7: Control code 5 (skip) advances `fetch_addr_o` by one and squashes the following slot.
- R8: In the cycle after any jump, call, return, computed jump or skip, `squash_o` is 1. The control code presented in a squashed cycle has no effect: the address advances by one, nothing is pushed or popped, and `lit_load_o` stays 0.
- R9: The return stack holds two addresses. A call made while it is full overwrites the oldest entry, and the next returns come back in last-in, first-out order.
- R10: A return made while the stack is empty goes to the address popped most recently (zero if nothing has been popped since reset).
- R11: The unused control codes 6 and 7 behave as sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Decoded control code of the executing instruction |
| imm_i | input | 9 | Address or literal field of the instruction |
| page_i | input | ADDR_W-9 | Page bits from the status register |
| wdata_i | input | 8 | Byte written to the low program-counter register |
| fetch_addr_o | output | ADDR_W | Address of the next fetch |
| lit_o | output | 8 | Literal for the accumulator from the last return |
| lit_load_o | output | 1 | One-cycle strobe: load `lit_o` into the accumulator |
| squash_o | output | 1 | The instruction in this slot must be discarded |

## Verification
The hardest states to reach are the two edges of the return stack: a third nested call that wraps over the oldest slot, and a return issued after the stack has drained. Each call and return is followed by a squashed slot that blocks stack traffic. The stimulus therefore places calls and returns on every other cycle and fills each squashed slot with a deliberately conflicting code. A long random run follows. In that run, squashed slots frequently mask calls and returns, and page bits change between instructions.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

   typedef enum logic [2:0] {
      OP_SEQ   = 3'd0,
      OP_GOTO  = 3'd1,
      OP_CALL  = 3'd2,
      OP_RETLW = 3'd3,
      OP_PCLWR = 3'd4,
      OP_SKIP  = 3'd5
   } seq_op_e;

   localparam int JUMP_BITS = 9;
   localparam int CALL_BITS = 8;

endpackage

// File: rtl/pc_rstack.sv
module pc_rstack #(
   parameter int AW    = 11,
   parameter int DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [AW-1:0] push_addr_i,
   output logic [AW-1:0] top_addr_o
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [AW-1:0] slot_q [DEPTH];
   logic [IW-1:0] top_q;
   logic [IW-1:0] wr_idx;
   logic [IW-1:0] dn_idx;
   logic [CW-1:0] cnt_q;

   assign wr_idx     = (top_q == IW'(DEPTH - 1)) ? '0 : top_q + IW'(1);
   assign dn_idx     = (top_q == '0) ? IW'(DEPTH - 1) : top_q - IW'(1);
   assign top_addr_o = slot_q[top_q];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[i] <= '0;
         else if (push_i && (wr_idx == IW'(i)))
            slot_q[i] <= push_addr_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q <= IW'(DEPTH - 1);
         cnt_q <= '0;
      end else if (push_i) begin
         top_q <= wr_idx;
         if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + CW'(1);
      end else if (pop_i) begin
         if (cnt_q > CW'(1)) top_q <= dn_idx;
         if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
      end
   end

   AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH)); // R9
   AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && cnt_q == '0) |=> top_addr_o == $past(top_addr_o)); // R10
   AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> top_addr_o == $past(push_addr_i)); // R4

endmodule

// File: rtl/pc_target.sv
module pc_target
   import pc_seq_pkg::*;
#(
   parameter int AW = 11
) (
   input  logic [2:0]       op_i,
   input  logic [AW-1:0]    pc_i,
   input  logic [AW-10:0]   page_i,
   input  logic [8:0]       imm_i,
   input  logic [7:0]       wdata_i,
   input  logic [AW-1:0]    pop_addr_i,
   output logic [AW-1:0]    next_pc_o,
   output logic             kill_o,
   output logic             push_o,
   output logic             pop_o
);
   always_comb begin
      next_pc_o = pc_i + AW'(1);
      kill_o    = 1'b0;
      push_o    = 1'b0;
      pop_o     = 1'b0;
      case (op_i)
         OP_GOTO: begin
            next_pc_o = {page_i, imm_i[JUMP_BITS-1:0]};
            kill_o    = 1'b1;
         end
         OP_CALL: begin
            next_pc_o = {page_i, 1'b0, imm_i[CALL_BITS-1:0]};
            kill_o    = 1'b1;
            push_o    = 1'b1;
         end
         OP_RETLW: begin
            next_pc_o = pop_addr_i;
            kill_o    = 1'b1;
            pop_o     = 1'b1;
         end
         OP_PCLWR: begin
            next_pc_o = {page_i, 1'b0, wdata_i};
            kill_o    = 1'b1;
         end
         OP_SKIP: kill_o = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/paged_pc_seq.sv
module paged_pc_seq
   import pc_seq_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int STACK_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_i,
   input  logic [8:0]        imm_i,
   input  logic [ADDR_W-10:0] page_i,
   input  logic [7:0]        wdata_i,
   output logic [ADDR_W-1:0] fetch_addr_o,
   output logic [7:0]        lit_o,
   output logic              lit_load_o,
   output logic              squash_o
);
   localparam int PG_W = ADDR_W - JUMP_BITS;

   if (PG_W < 1 || ADDR_W > 16) begin : g_bad_width
      $error("paged_pc_seq: ADDR_W must lie in 10..16");
   end
   if (STACK_DEPTH < 1 || STACK_DEPTH > 16) begin : g_bad_depth
      $error("paged_pc_seq: STACK_DEPTH must lie in 1..16");
   end

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] next_pc;
   logic [ADDR_W-1:0] pop_addr;
   logic [2:0]        eff_op;
   logic              squash_q;
   logic              kill;
   logic              push;
   logic              pop;
   logic [7:0]        lit_q;
   logic              lit_load_q;

   // a squashed slot executes as a plain sequential step
   assign eff_op = squash_q ? OP_SEQ : op_i;

   pc_target #(.AW(ADDR_W)) u_target (
      .op_i       (eff_op),
      .pc_i       (pc_q),
      .page_i     (page_i),
      .imm_i      (imm_i),
      .wdata_i    (wdata_i),
      .pop_addr_i (pop_addr),
      .next_pc_o  (next_pc),
      .kill_o     (kill),
      .push_o     (push),
      .pop_o      (pop)
   );

   pc_rstack #(.AW(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .pop_i       (pop),
      .push_addr_i (pc_q),
      .top_addr_o  (pop_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q       <= '1;
         squash_q   <= 1'b0;
         lit_q      <= '0;
         lit_load_q <= 1'b0;
      end else begin
         pc_q       <= next_pc;
         squash_q   <= kill;
         lit_load_q <= pop;
         if (pop) lit_q <= imm_i[7:0];
      end
   end

   assign fetch_addr_o = pc_q;
   assign squash_o     = squash_q;
   assign lit_o        = lit_q;
   assign lit_load_o   = lit_load_q;

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!squash_o && (op_i == OP_SEQ)) |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1)); // R2
   AST_GOTO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      (!squash_o && (op_i == OP_GOTO)) |=> fetch_addr_o == {$past(page_i), $past(imm_i)}); // R3
   AST_CALL_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (!squash_o && (op_i == OP_CALL)) |=> !fetch_addr_o[8]); // R4
   AST_LIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!squash_o && (op_i == OP_RETLW)) |=> (lit_load_o && lit_o == $past(imm_i[7:0]))); // R5
   AST_SQUASH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (!squash_o && (op_i inside {OP_GOTO, OP_CALL, OP_RETLW, OP_PCLWR, OP_SKIP})) |=> squash_o); // R8
   AST_SQUASH_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      squash_o |=> (fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1) && !lit_load_o)); // R8

endmodule

// File: tb/paged_pc_seq_bench.sv
module paged_pc_seq_bench;
   localparam int AW    = 11;
   localparam int DEPTH = 2;
   localparam int MASK  = (1 << AW) - 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [2:0]     op = '0;
   logic [8:0]     imm = '0;
   logic [AW-10:0] page = '0;
   logic [7:0]     wd = '0;
   logic [AW-1:0]  fetch_addr;
   logic [7:0]     lit;
   logic           lit_load;
   logic           squash;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R1";

   // behavioural reference state
   int m_pc = MASK;
   bit m_sq = 1'b0;
   int m_lit = 0;
   bit m_litv = 1'b0;
   int m_last = 0;
   int stk[$];

   always #10 clk = ~clk;

   paged_pc_seq #(.ADDR_W(AW), .STACK_DEPTH(DEPTH)) u_paged_pc_seq (
      .clk(clk), .rst_n(rst_n), .op_i(op), .imm_i(imm), .page_i(page),
      .wdata_i(wd), .fetch_addr_o(fetch_addr), .lit_o(lit),
      .lit_load_o(lit_load), .squash_o(squash)
   );

   always @(posedge clk) begin
      int e;
      bit nsq;
      if (!rst_n) begin
         m_pc = MASK; m_sq = 0; m_lit = 0; m_litv = 0; m_last = 0;
         stk.delete();
      end else begin
         e = m_sq ? 0 : int'(op);
         if (e > 5) e = 0;            // R11
         nsq = 0;
         m_litv = 0;
         case (e)
            1: begin m_pc = (int'(page) << 9) | int'(imm); nsq = 1; end
            2: begin
               stk.push_back(m_pc);
               if (stk.size() > DEPTH) void'(stk.pop_front());
               m_pc = (int'(page) << 9) | (int'(imm) & 255);
               nsq = 1;
            end
            3: begin
               if (stk.size() > 0) m_last = stk.pop_back();
               m_pc = m_last; m_lit = int'(imm) & 255; m_litv = 1; nsq = 1;
            end
            4: begin m_pc = (int'(page) << 9) | int'(wd); nsq = 1; end
            5: begin m_pc = (m_pc + 1) & MASK; nsq = 1; end
            default: m_pc = (m_pc + 1) & MASK;
         endcase
         m_sq = nsq;
      end
   end

   task automatic check1(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      check1("fetch_addr", int'(fetch_addr), m_pc);
      check1("squash", int'(squash), int'(m_sq));
      check1("lit_load", int'(lit_load), int'(m_litv));
      check1("lit", int'(lit), m_lit);
   endtask

   task automatic cyc(input logic [2:0] o, input int im, input int pg,
                      input int w, input string t);
      @(negedge clk);
      check_all();
      op = o; imm = im[8:0]; page = pg[AW-10:0]; wd = w[7:0];
      cur_tag = t;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cur_tag = "R1";
      check1("reset fetch_addr", int'(fetch_addr), MASK);
      check1("reset squash", int'(squash), 0);
      check1("reset lit_load", int'(lit_load), 0);
      rst_n = 1'b1;
      cyc(0, 0, 0, 0, "R2");          // wrap all ones -> 0
      cyc(0, 0, 0, 0, "R2");
      cyc(1, 'h1A5, 2, 0, "R3");      // jump
      cyc(2, 'h0FF, 3, 0, "R8");      // call in squashed slot: ignored
      cyc(2, 'h1FF, 1, 0, "R4");      // call, bit 8 forced low
      cyc(3, 'h055, 0, 0, "R8");      // return in squashed slot: ignored
      cyc(2, 'h033, 2, 0, "R4");      // second nested call
      cyc(0, 0, 0, 0, "R8");
      cyc(2, 'h0C4, 0, 0, "R9");      // third call overwrites oldest
      cyc(0, 0, 0, 0, "R8");
      cyc(3, 'h0A1, 0, 0, "R9");
      cyc(0, 0, 0, 0, "R5");
      cyc(3, 'h0B2, 0, 0, "R9");
      cyc(0, 0, 0, 0, "R5");
      cyc(3, 'h1C3, 0, 0, "R10");     // empty: same address again
      cyc(0, 0, 0, 0, "R5");
      cyc(3, 'h0D4, 0, 0, "R10");
      cyc(0, 0, 0, 0, "R5");
      cyc(4, 0, 3, 'h7E, "R6");       // computed jump
      cyc(4, 0, 1, 'hFF, "R8");
      cyc(0, 0, 0, 0, "R6");
      cyc(5, 0, 0, 0, "R7");          // skip
      cyc(1, 'h111, 1, 0, "R7");      // squashed jump
      cyc(6, 'h1FF, 3, 0, "R11");
      cyc(7, 'h1FF, 3, 'hAA, "R11");
      cyc(2, 'h010, 1, 0, "R4");
      cyc(0, 0, 0, 0, "R8");
      cyc(4, 0, 0, 'h20, "R6");       // table entry jump
      cyc(0, 0, 0, 0, "R8");
      cyc(3, 'h09C, 0, 0, "R5");      // table return with literal
      cyc(0, 0, 0, 0, "R5");
      for (int i = 0; i < 600; i++) begin
         int r;
         r = $urandom_range(0, 9);
         cyc((r > 7) ? 3'(r - 8) : 3'(r), int'($urandom_range(0, 511)),
             int'($urandom_range(0, 3)), int'($urandom_range(0, 255)), "R8");
      end
      cyc(0, 0, 0, 0, "R2");
      @(negedge clk);
      check_all();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule